// File: doc/BRIEF.md
# Nonvolatile Memory Protection Controller

This block guards a 4 KB nonvolatile data memory against unwanted program and erase commands. It holds one 8-bit protection control register. On reset the register takes the stored configuration byte that lives at offset 0x0FFD of the memory. Software may read the register at any time. Through the register port it may only make protection stricter, never weaker.

Every command request carries an operation type and a 12-bit address offset. The block compares each request with the current register contents and answers in the same cycle with either a grant or a deny. A refused command never reaches the memory. It also sets a sticky violation flag, which software clears by writing 1 through a separate status strobe.

The protected window always ends at the top offset 0x0FFF. Its size is 64 bytes shifted left by a 3-bit size code. A size that reaches the array size covers the whole 4 KB.

Top module: `nvm_prot_ctrl`

## Requirements
- R1: While `rst` is high on a rising clock edge, the register loads `cfg_byte` and the violation flag clears. From the next cycle `reg_rdata` equals that byte and `viol` is 0.
- R2: `reg_rdata` always shows the current register. Bits 6:4 are read-only and keep the value loaded at reset, whatever is written.
- R3: Bit 7 (open) and bit 3 (range-off) can only go from 1 to 0. A write stores the AND of the current bit and the written bit.
- R4: Bits 2:0 (size code) take the written value only if bit 3 is 1 before the write. Otherwise they keep their value.
- R5: While bit 7 is 0, every command is denied.
- R6: While bit 7 is 1 and bit 3 is 0, a program or sector-erase command is denied exactly when its address is at or above S. Here S = 4096 - 64·2^code when that is positive, and S = 0 otherwise.
- R7: While bits 7 and 3 are both 1, program and sector-erase commands are granted at every address.
- R8: A mass erase (`cmd_op` = 2 or 3) is granted only when bits 7 and 3 are both 1. Program is `cmd_op` = 0 and sector erase is `cmd_op` = 1.
- R9: `cmd_grant` and `cmd_deny` are 0 when `cmd_valid` is 0. Otherwise exactly one of them is 1, in the same cycle as the request. A deny sets `viol` from the next cycle onward.
- R10: `viol` stays set until a cycle with `stat_wr` = 1 and `stat_wd` = 1. `stat_wd` = 0 has no effect, and a deny in the same cycle as a clear keeps `viol` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_byte | input | 8 | Stored configuration byte loaded at reset |
| reg_wr | input | 1 | Protection register write strobe |
| reg_wdata | input | 8 | Protection register write data |
| reg_rdata | output | 8 | Current protection register value |
| stat_wr | input | 1 | Status write strobe |
| stat_wd | input | 1 | Status write data, 1 clears the violation flag |
| cmd_valid | input | 1 | Command request present |
| cmd_op | input | 2 | 0 program, 1 sector erase, 2 or 3 mass erase |
| cmd_addr | input | 12 | Target byte offset |
| cmd_grant | output | 1 | Command allowed |
| cmd_deny | output | 1 | Command refused |
| viol | output | 1 | Sticky protection violation flag |

## Verification
The hardest states to reach are the window boundaries for every size code combined with every mix of the open and range-off bits. Some of these states cannot be entered at run time once a bit has been cleared, because bits can only be cleared. The bench therefore resets through all 256 configuration bytes. For each byte it probes offset 0, the cell just below the window start, the window start and the top offset, with every operation type. It then tries two loosening writes and checks that the register moves only toward more protection.

// File: rtl/nvm_prot_pkg.sv
package nvm_prot_pkg;

    typedef struct packed {
        logic       open_en;
        logic [2:0] rsvd;
        logic       range_off;
        logic [2:0] win_code;
    } prot_reg_t;

    typedef enum logic [1:0] {
        OP_PROG  = 2'd0,
        OP_SECT  = 2'd1,
        OP_MASS  = 2'd2,
        OP_MASS2 = 2'd3
    } cmd_op_e;

    function automatic logic is_mass(input logic [1:0] op);
        return op[1];
    endfunction

endpackage

// File: rtl/nvm_prot_reg.sv
module nvm_prot_reg
    import nvm_prot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] cfg_byte,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output prot_reg_t  cur
);
    prot_reg_t wr_view;
    prot_reg_t nxt;

    always_comb begin
        wr_view       = prot_reg_t'(wdata);
        nxt.open_en   = cur.open_en & wr_view.open_en;
        nxt.range_off = cur.range_off & wr_view.range_off;
        nxt.rsvd      = cur.rsvd;
        nxt.win_code  = cur.range_off ? wr_view.win_code : cur.win_code;
    end

    always_ff @(posedge clk) begin
        if (rst)        cur <= prot_reg_t'(cfg_byte);
        else if (wr_en) cur <= nxt;
    end

    // R3
    open_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cur.open_en) |-> $past(rst));
    // R3
    roff_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cur.range_off) |-> $past(rst));
    // R4
    code_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cur.range_off)) |-> $stable(cur.win_code));
    // R2
    rsvd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(cur.rsvd));
endmodule

// File: rtl/nvm_prot_check.sv
module nvm_prot_check
    import nvm_prot_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int MIN_WIN_LOG2 = 6
) (
    input  logic              open_en,
    input  logic              range_off,
    input  logic [2:0]        win_code,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              grant,
    output logic              deny
);
    localparam int MEM_BYTES = 1 << ADDR_W;

    int          win_log2;
    logic [ADDR_W:0] win_start;
    logic        in_window;
    logic        allowed;

    always_comb begin
        win_log2 = MIN_WIN_LOG2 + int'(win_code);
        if (win_log2 >= ADDR_W)
            win_start = '0;
        else
            win_start = (ADDR_W+1)'(MEM_BYTES - (1 << win_log2));
        in_window = {1'b0, cmd_addr} >= win_start;

        if (is_mass(cmd_op))
            allowed = open_en & range_off;
        else if (!open_en)
            allowed = 1'b0;
        else if (range_off)
            allowed = 1'b1;
        else
            allowed = !in_window;

        grant = cmd_valid & allowed;
        deny  = cmd_valid & !allowed;
    end
endmodule

// File: rtl/nvm_viol_flag.sv
module nvm_viol_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (set_req) flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

    // R9
    viol_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_req |=> flag);
    // R10
    viol_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_req) |=> flag);
endmodule

// File: rtl/nvm_prot_ctrl.sv
module nvm_prot_ctrl
    import nvm_prot_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int MIN_WIN_LOG2 = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        cfg_byte,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              stat_wr,
    input  logic              stat_wd,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_grant,
    output logic              cmd_deny,
    output logic              viol
);
    prot_reg_t cur;

    nvm_prot_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .cfg_byte (cfg_byte),
        .wr_en    (reg_wr),
        .wdata    (reg_wdata),
        .cur      (cur)
    );

    nvm_prot_check #(
        .ADDR_W       (ADDR_W),
        .MIN_WIN_LOG2 (MIN_WIN_LOG2)
    ) u_check (
        .open_en   (cur.open_en),
        .range_off (cur.range_off),
        .win_code  (cur.win_code),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .grant     (cmd_grant),
        .deny      (cmd_deny)
    );

    nvm_viol_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_req (cmd_deny),
        .clr_req (stat_wr & stat_wd),
        .flag    (viol)
    );

    assign reg_rdata = cur;

    // R9
    grant_deny_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({cmd_grant, cmd_deny}) == (cmd_valid ? 1 : 0));
    // R5
    closed_denies_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !reg_rdata[7]) |-> cmd_deny);
    // R8
    mass_needs_open_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_grant && cmd_op[1]) |-> (reg_rdata[7] && reg_rdata[3]));
    // R7
    fully_open_grants_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_op[1] && reg_rdata[7] && reg_rdata[3]) |-> cmd_grant);
endmodule

// File: tb/nvm_prot_ctrl_tb.sv
module nvm_prot_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_byte = 8'h00;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        stat_wr = 1'b0;
    logic        stat_wd = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [11:0] cmd_addr = 12'd0;
    logic        cmd_grant, cmd_deny, viol;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    bit exp_viol;
    logic [7:0] model;

    always #4 clk = ~clk;

    nvm_prot_ctrl u_dut (
        .clk(clk), .rst(rst), .cfg_byte(cfg_byte),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .stat_wr(stat_wr), .stat_wd(stat_wd),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_grant(cmd_grant), .cmd_deny(cmd_deny), .viol(viol)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int win_start(input logic [2:0] code);
        int sz = 64 << code;
        return (sz >= 4096) ? 0 : 4096 - sz;
    endfunction

    function automatic bit exp_allow(input logic [7:0] r, input logic [1:0] op, input int addr);
        if (op[1])      return r[7] & r[3];
        if (!r[7])      return 1'b0;
        if (r[3])       return 1'b1;
        return addr < win_start(r[2:0]);
    endfunction

    function automatic string tag_of(input logic [7:0] r, input logic [1:0] op);
        if (op[1])  return "R8";
        if (!r[7])  return "R5";
        if (r[3])   return "R7";
        return "R6";
    endfunction

    function automatic logic [7:0] exp_write(input logic [7:0] c, input logic [7:0] w);
        logic [7:0] n;
        n[7]   = c[7] & w[7];
        n[6:4] = c[6:4];
        n[3]   = c[3] & w[3];
        n[2:0] = c[3] ? w[2:0] : c[2:0];
        return n;
    endfunction

    task automatic do_reset(input logic [7:0] b);
        @(negedge clk);
        rst = 1'b1; cfg_byte = b;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(reg_rdata == b, "R1", reg_rdata, b);
        check(viol == 1'b0, "R1", viol, 0);
        exp_viol = 0;
        model = b;
    endtask

    task automatic do_cmd(input logic [1:0] op, input int addr, input bit clr);
        bit ea;
        string t;
        ea = exp_allow(model, op, addr);
        t  = tag_of(model, op);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = 12'(addr);
        stat_wr = clr; stat_wd = clr;
        #1;
        check(cmd_grant == ea && cmd_deny == !ea, t, {cmd_grant, cmd_deny}, {ea, !ea});
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; stat_wr = 1'b0; stat_wd = 1'b0;
        if (!ea) exp_viol = 1;
        else if (clr) exp_viol = 0;
        #1;
        check(viol == exp_viol, "R9", viol, exp_viol);
    endtask

    task automatic do_stat(input bit d);
        @(negedge clk);
        stat_wr = 1'b1; stat_wd = d;
        @(posedge clk);
        @(negedge clk);
        stat_wr = 1'b0; stat_wd = 1'b0;
        if (d) exp_viol = 0;
        #1;
        check(viol == exp_viol, "R10", viol, exp_viol);
    endtask

    task automatic do_write(input logic [7:0] w);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = w;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        model = exp_write(model, w);
        #1;
        check(reg_rdata[7] == model[7] && reg_rdata[3] == model[3], "R3", reg_rdata, model);
        check(reg_rdata[2:0] == model[2:0], "R4", reg_rdata, model);
        check(reg_rdata[6:4] == model[6:4], "R2", reg_rdata, model);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 256; c++) begin
            int st;
            do_reset(8'(c));
            st = win_start(model[2:0]);
            for (int op = 0; op < 4; op++) begin
                do_cmd(2'(op), 0, 0);
                if (st > 0) do_cmd(2'(op), st - 1, 0);
                do_cmd(2'(op), st, 0);
                do_cmd(2'(op), 4095, 0);
            end
            if (exp_viol) begin
                do_stat(1'b0);
                do_stat(1'b1);
            end
            do_write(~model);
            do_write(8'(c * 37 + 11));
            do_cmd(2'd0, win_start(model[2:0]), 0);
            do_cmd(2'd2, 100, 0);
        end
        // R10: deny and clear together keep the flag set
        do_reset(8'h00);
        do_cmd(2'd0, 5, 1);
        check(viol == 1'b1, "R10", viol, 1);
        do_stat(1'b1);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule